// File: doc/BRIEF.md
# I2C Master START Condition Generator

This block produces the START condition for an I2C bus master. A register-side write sets the start request bit. The block then watches the open-drain SDA and SCL lines and times the sequence with a reloadable 7-bit down-counter. With both lines high for one full baud period, it pulls SDA low while SCL stays high and raises the START-seen status. It then waits a second baud period and retires the request. When the START is complete, SDA is left held low for the data phase that follows.

If either line is low when the request is taken, or if SCL drops (or SDA is not still high) during the first period, the block flags a bus collision. In that case it drops the request and returns to idle with both lines released.

While a START is in progress, the transmit buffer and the command bits are locked. A buffer write during that time raises a sticky write-collision flag, and command writes are dropped. The interrupt, bus-collision and write-collision flags stay set until the register side pulses the matching clear input.

Top module: `i2c_start_gen`

## Requirements
- R1: After a synchronous reset, both line drives are released, the command bits, buffer, reload value, START-seen status and all three flags read zero, and the baud counter is stopped.
- R2: Bit 0 of the command bits is the start request. When it is set and both lines are sampled high on the next clock, the counter loads the reload value. SDA is driven low, and START-seen is set, reload+2 clocks after the clock edge that stored the request. SCL is never driven.
- R3: A second period of reload+1 clocks follows the SDA fall. When it ends, command bit 0 clears and the interrupt flag sets, so the interrupt flag appears 2*reload+3 clocks after the request write. SDA stays driven low afterwards.
- R4: If SDA or SCL is low on the clock that takes the request (including SDA still held low by this block after an earlier START), the bus-collision flag sets, command bit 0 clears, START-seen clears, and SDA is released.
- R5: If SCL is sampled low during the first period, the START aborts with the same effects as R4.
- R6: If SDA is not high when the first period expires, the START aborts with the same effects as R4, and SDA is never driven low.
- R7: A buffer write while command bit 0 is set leaves the buffer unchanged and sets the write-collision flag. A buffer write at any other time stores the data and leaves the flag unchanged.
- R8: A command write while command bit 0 is set is ignored entirely. Command bits 4:1 (restart, stop, receive-enable and ack-enable requests) are only stored, and they are accepted again once the START finishes.
- R9: The interrupt, bus-collision and write-collision flags are sticky. Each stays set until its own clear pulse, and a flag being set wins over its clear in the same clock.
- R10: The reload register takes a new value on a reload write. Each baud period lasts (reload + 1) clocks, using the reload value present when the counter loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command bits write strobe |
| cmd_wdata | input | CMD_W | Command write data, bit 0 is the start request |
| cmd_bits | output | CMD_W | Current command bits |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | BRG_W | Baud reload value |
| buf_we | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W | Transmit buffer write data |
| buf_q | output | DATA_W | Transmit buffer contents |
| clr_irq | input | 1 | Clear pulse for the interrupt flag |
| clr_bcol | input | 1 | Clear pulse for the bus-collision flag |
| clr_wcol | input | 1 | Clear pulse for the write-collision flag |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| start_seen | output | 1 | START-seen status |
| irq_flag | output | 1 | START complete interrupt flag |
| bcol_flag | output | 1 | Bus-collision flag |
| wcol_flag | output | 1 | Write-collision flag |

## Verification
A sequencer stuck in the wrong phase, or a counter off by one, shows as SDA falling or the interrupt flag rising a clock early or late. It also shows as a spurious collision flag, visible within one baud period of the request. A lock that releases too early shows as the buffer or command bits changing on the very next clock after a busy write. A flag that fails to stick shows as it dropping one clock after it should have held. The reference model is compared against every output on each clock, so any of these faults is caught in the cycle where it first appears.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_WAIT2 = 2'd2
  } st_e;

  // events raised by the sequencer for one clock
  typedef struct packed {
    logic load;      // load baud counter from reload register
    logic halt;      // stop baud counter
    logic set_s;     // START seen
    logic set_irq;   // START complete
    logic set_bcol;  // bus collision, abort
    logic finish;    // clear the start request bit
  } ev_t;

  localparam int NFLAG   = 3;
  localparam int FL_IRQ  = 0;
  localparam int FL_BCOL = 1;
  localparam int FL_WCOL = 2;

endpackage

// File: rtl/i2c_start_baud.sv
module i2c_start_baud #(
  parameter int BRG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             halt,
  input  logic [BRG_W-1:0] reload,
  output logic             expired
);

  logic [BRG_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= reload;
      run_q <= 1'b1;
    end else if (halt) begin
      run_q <= 1'b0;
    end else if (run_q && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);

endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic sda_in,
  input  logic scl_in,
  input  logic expired,
  output ev_t  ev,
  output logic sda_low
);

  st_e  st_q, st_d;
  logic sda_d;

  always_comb begin
    st_d  = st_q;
    sda_d = sda_low;
    ev    = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          if (sda_in && scl_in) begin
            ev.load = 1'b1;
            st_d    = ST_WAIT1;
          end else begin
            ev.set_bcol = 1'b1;
            ev.finish   = 1'b1;
            sda_d       = 1'b0;
          end
        end
      end
      ST_WAIT1: begin
        if (!scl_in) begin
          ev.set_bcol = 1'b1;
          ev.finish   = 1'b1;
          ev.halt     = 1'b1;
          sda_d       = 1'b0;
          st_d        = ST_IDLE;
        end else if (expired) begin
          if (sda_in) begin
            sda_d    = 1'b1;
            ev.set_s = 1'b1;
            ev.load  = 1'b1;
            st_d     = ST_WAIT2;
          end else begin
            ev.set_bcol = 1'b1;
            ev.finish   = 1'b1;
            ev.halt     = 1'b1;
            sda_d       = 1'b0;
            st_d        = ST_IDLE;
          end
        end
      end
      ST_WAIT2: begin
        if (expired) begin
          ev.halt    = 1'b1;
          ev.set_irq = 1'b1;
          ev.finish  = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      sda_low <= 1'b0;
    end else begin
      st_q    <= st_d;
      sda_low <= sda_d;
    end
  end

endmodule

// File: rtl/i2c_start_regs.sv
module i2c_start_regs
  import i2c_start_pkg::*;
#(
  parameter int CMD_W  = 5,
  parameter int BRG_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              reload_we,
  input  logic [BRG_W-1:0]  reload_wdata,
  input  logic              buf_we,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic [NFLAG-1:0]  clr_v,
  input  ev_t               ev,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [BRG_W-1:0]  reload_q,
  output logic [DATA_W-1:0] buf_q,
  output logic [NFLAG-1:0]  flag_q,
  output logic              seen_q
);

  logic             busy;
  logic [NFLAG-1:0] set_v;

  assign busy = cmd_q[0];

  always_comb begin
    set_v          = '0;
    set_v[FL_IRQ]  = ev.set_irq;
    set_v[FL_BCOL] = ev.set_bcol;
    set_v[FL_WCOL] = buf_we && busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      reload_q <= '0;
      buf_q    <= '0;
      flag_q   <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (cmd_we && !busy) begin
        cmd_q <= cmd_wdata;
      end else if (ev.finish) begin
        cmd_q[0] <= 1'b0;
      end
      if (reload_we) begin
        reload_q <= reload_wdata;
      end
      if (buf_we && !busy) begin
        buf_q <= buf_wdata;
      end
      flag_q <= set_v | (flag_q & ~clr_v);
      if (ev.set_bcol) begin
        seen_q <= 1'b0;
      end else if (ev.set_s) begin
        seen_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int CMD_W  = 5,
  parameter int BRG_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_bits,
  input  logic              reload_we,
  input  logic [BRG_W-1:0]  reload_wdata,
  input  logic              buf_we,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic [DATA_W-1:0] buf_q,
  input  logic              clr_irq,
  input  logic              clr_bcol,
  input  logic              clr_wcol,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_drive_low,
  output logic              scl_drive_low,
  output logic              start_seen,
  output logic              irq_flag,
  output logic              bcol_flag,
  output logic              wcol_flag
);

  ev_t              ev;
  logic             expired;
  logic [BRG_W-1:0] reload_q;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] clr_v;

  always_comb begin
    clr_v          = '0;
    clr_v[FL_IRQ]  = clr_irq;
    clr_v[FL_BCOL] = clr_bcol;
    clr_v[FL_WCOL] = clr_wcol;
  end

  i2c_start_regs #(
    .CMD_W (CMD_W),
    .BRG_W (BRG_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .cmd_we      (cmd_we),
    .cmd_wdata   (cmd_wdata),
    .reload_we   (reload_we),
    .reload_wdata(reload_wdata),
    .buf_we      (buf_we),
    .buf_wdata   (buf_wdata),
    .clr_v       (clr_v),
    .ev          (ev),
    .cmd_q       (cmd_bits),
    .reload_q    (reload_q),
    .buf_q       (buf_q),
    .flag_q      (flag_q),
    .seen_q      (start_seen)
  );

  i2c_start_baud #(.BRG_W(BRG_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load   (ev.load),
    .halt   (ev.halt),
    .reload (reload_q),
    .expired(expired)
  );

  i2c_start_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_req(cmd_bits[0]),
    .sda_in   (sda_in),
    .scl_in   (scl_in),
    .expired  (expired),
    .ev       (ev),
    .sda_low  (sda_drive_low)
  );

  assign scl_drive_low = 1'b0;
  assign irq_flag      = flag_q[FL_IRQ];
  assign bcol_flag     = flag_q[FL_BCOL];
  assign wcol_flag     = flag_q[FL_WCOL];

endmodule

// File: rtl/i2c_start_chk.sv
module i2c_start_chk #(
  parameter int CMD_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_we,
  input logic [CMD_W-1:0]  cmd_bits,
  input logic              buf_we,
  input logic [DATA_W-1:0] buf_q,
  input logic              clr_irq,
  input logic              sda_drive_low,
  input logic              start_seen,
  input logic              irq_flag,
  input logic              bcol_flag,
  input logic              wcol_flag
);

  assert_sda_fall_seen_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> start_seen);

  assert_done_holds_sda_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> (sda_drive_low && !cmd_bits[0]));

  assert_abort_releases_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bcol_flag) |-> (!sda_drive_low && !cmd_bits[0] && !start_seen));

  assert_buf_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (buf_we && cmd_bits[0]) |=> ($stable(buf_q) && wcol_flag));

  assert_cmd_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_bits[0]) |=> (cmd_bits[CMD_W-1:1] == $past(cmd_bits[CMD_W-1:1])));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !clr_irq) |=> irq_flag);

endmodule

bind i2c_start_gen i2c_start_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_we       (cmd_we),
  .cmd_bits     (cmd_bits),
  .buf_we       (buf_we),
  .buf_q        (buf_q),
  .clr_irq      (clr_irq),
  .sda_drive_low(sda_drive_low),
  .start_seen   (start_seen),
  .irq_flag     (irq_flag),
  .bcol_flag    (bcol_flag),
  .wcol_flag    (wcol_flag)
);

// File: tb/i2c_start_gen_tb.sv
`timescale 1ns/1ps
module i2c_start_gen_tb;
  localparam int CMD_W  = 5;
  localparam int BRG_W  = 7;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst;
  logic              cmd_we, reload_we, buf_we;
  logic [CMD_W-1:0]  cmd_wdata;
  logic [BRG_W-1:0]  reload_wdata;
  logic [DATA_W-1:0] buf_wdata;
  logic              clr_irq, clr_bcol, clr_wcol;
  logic              ext_sda_low, ext_scl_low;
  logic [CMD_W-1:0]  cmd_bits;
  logic [DATA_W-1:0] buf_q;
  logic              sda_drive_low, scl_drive_low;
  logic              start_seen, irq_flag, bcol_flag, wcol_flag;
  wire               sda_in = ~(sda_drive_low | ext_sda_low);
  wire               scl_in = ~(scl_drive_low | ext_scl_low);

  int total = 0;
  int bad   = 0;

  i2c_start_gen #(.CMD_W(CMD_W), .BRG_W(BRG_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_bits(cmd_bits),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_q(buf_q),
    .clr_irq(clr_irq), .clr_bcol(clr_bcol), .clr_wcol(clr_wcol),
    .sda_in(sda_in), .scl_in(scl_in),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .start_seen(start_seen), .irq_flag(irq_flag),
    .bcol_flag(bcol_flag), .wcol_flag(wcol_flag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 first period, 2 second period
  int               m_phase, m_left;
  logic [CMD_W-1:0] m_cmd;
  logic [DATA_W-1:0] m_buf;
  logic [BRG_W-1:0] m_reload;
  bit               m_sda, m_s, m_irq, m_bcol, m_wcol;

  always @(posedge clk) begin : ref_model
    bit sd, sc, fin, hit_b, hit_s, hit_i, busy;
    if (rst) begin
      m_phase = 0; m_left = 0; m_cmd = '0; m_buf = '0; m_reload = '0;
      m_sda = 0; m_s = 0; m_irq = 0; m_bcol = 0; m_wcol = 0;
    end else begin
      sd = !(m_sda || ext_sda_low);
      sc = !ext_scl_low;
      busy = m_cmd[0];
      fin = 0; hit_b = 0; hit_s = 0; hit_i = 0;
      if (m_phase == 0) begin
        if (busy) begin
          if (sd && sc) begin m_phase = 1; m_left = int'(m_reload); end
          else begin hit_b = 1; fin = 1; m_sda = 0; end
        end
      end else if (m_phase == 1) begin
        if (!sc) begin hit_b = 1; fin = 1; m_sda = 0; m_phase = 0; end
        else if (m_left == 0) begin
          if (sd) begin m_sda = 1; hit_s = 1; m_left = int'(m_reload); m_phase = 2; end
          else begin hit_b = 1; fin = 1; m_sda = 0; m_phase = 0; end
        end else m_left--;
      end else begin
        if (m_left == 0) begin hit_i = 1; fin = 1; m_phase = 0; end
        else m_left--;
      end
      m_wcol = (buf_we && busy) || (m_wcol && !clr_wcol);
      m_irq  = hit_i || (m_irq && !clr_irq);
      m_bcol = hit_b || (m_bcol && !clr_bcol);
      if (hit_b) m_s = 0; else if (hit_s) m_s = 1;
      if (buf_we && !busy) m_buf = buf_wdata;
      if (cmd_we && !busy) m_cmd = cmd_wdata;
      else if (fin) m_cmd[0] = 1'b0;
      if (reload_we) m_reload = reload_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "sda_drive_low", int'(sda_drive_low), int'(m_sda));
      chk("R2", "scl_drive_low", int'(scl_drive_low), 0);
      chk("R2", "start_seen", int'(start_seen), int'(m_s));
      chk("R8", "cmd_bits", int'(cmd_bits), int'(m_cmd));
      chk("R7", "buf_q", int'(buf_q), int'(m_buf));
      chk("R3", "irq_flag", int'(irq_flag), int'(m_irq));
      chk("R4", "bcol_flag", int'(bcol_flag), int'(m_bcol));
      chk("R7", "wcol_flag", int'(wcol_flag), int'(m_wcol));
    end
  end

  task automatic wr_cmd(input logic [CMD_W-1:0] v);
    @(negedge clk); cmd_we = 1; cmd_wdata = v;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic wr_reload(input logic [BRG_W-1:0] v);
    @(negedge clk); reload_we = 1; reload_wdata = v;
    @(negedge clk); reload_we = 0;
  endtask
  task automatic wr_buf(input logic [DATA_W-1:0] v);
    @(negedge clk); buf_we = 1; buf_wdata = v;
    @(negedge clk); buf_we = 0;
  endtask
  task automatic pulse_clr(input int which);
    @(negedge clk);
    clr_irq = (which == 0); clr_bcol = (which == 1); clr_wcol = (which == 2);
    @(negedge clk); clr_irq = 0; clr_bcol = 0; clr_wcol = 0;
  endtask

  // request a START and measure the SDA fall and the interrupt delays
  task automatic timed_start(input int rl);
    int n;
    wr_reload(rl[BRG_W-1:0]);
    wr_cmd(5'b00001);
    n = 0;
    while (!sda_drive_low && n < 400) begin @(negedge clk); n++; end
    chk("R2", "edges to SDA fall", n, rl + 2);
    chk("R2", "start_seen at fall", int'(start_seen), 1);
    while (!irq_flag && n < 400) begin @(negedge clk); n++; end
    chk("R3", "edges to interrupt", n, 2 * rl + 3);
    chk("R3", "start bit cleared", int'(cmd_bits[0]), 0);
    chk("R10", "period follows reload", n - (rl + 2), rl + 1);
    repeat (4) @(negedge clk);
    chk("R3", "SDA still held", int'(sda_drive_low), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; cmd_we = 0; reload_we = 0; buf_we = 0;
    cmd_wdata = '0; reload_wdata = '0; buf_wdata = '0;
    clr_irq = 0; clr_bcol = 0; clr_wcol = 0;
    ext_sda_low = 0; ext_scl_low = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "reset lines", int'({sda_drive_low, scl_drive_low}), 0);
    chk("R1", "reset regs", int'({cmd_bits, buf_q}), 0);
    chk("R1", "reset flags", int'({start_seen, irq_flag, bcol_flag, wcol_flag}), 0);

    // normal START, reload 3
    timed_start(3);
    pulse_clr(0);
    chk("R9", "irq cleared by pulse", int'(irq_flag), 0);

    // new request while SDA is still held by the block
    wr_cmd(5'b00001);
    @(negedge clk);
    chk("R4", "collision on held SDA", int'(bcol_flag), 1);
    chk("R4", "SDA released", int'(sda_drive_low), 0);
    chk("R4", "start bit dropped", int'(cmd_bits[0]), 0);
    chk("R4", "start_seen cleared", int'(start_seen), 0);
    repeat (4) @(negedge clk);
    chk("R9", "bcol sticky", int'(bcol_flag), 1);
    pulse_clr(1);
    chk("R9", "bcol cleared", int'(bcol_flag), 0);

    // SCL low at request
    ext_scl_low = 1;
    wr_cmd(5'b00001);
    @(negedge clk);
    chk("R4", "collision on SCL low", int'(bcol_flag), 1);
    chk("R4", "start bit dropped", int'(cmd_bits[0]), 0);
    ext_scl_low = 0;
    pulse_clr(1);

    // SCL drops during first period
    wr_reload(6);
    wr_cmd(5'b00001);
    @(negedge clk);
    ext_scl_low = 1;
    @(negedge clk);
    ext_scl_low = 0;
    @(negedge clk);
    chk("R5", "collision in first period", int'(bcol_flag), 1);
    chk("R5", "SDA not driven", int'(sda_drive_low), 0);
    chk("R5", "start bit dropped", int'(cmd_bits[0]), 0);
    pulse_clr(1);

    // SDA pulled low by another device across first-period expiry
    wr_reload(4);
    wr_cmd(5'b00001);
    @(negedge clk);
    ext_sda_low = 1;
    repeat (8) @(negedge clk);
    ext_sda_low = 0;
    chk("R6", "collision on SDA low", int'(bcol_flag), 1);
    chk("R6", "no START seen", int'(start_seen), 0);
    chk("R6", "SDA not driven", int'(sda_drive_low), 0);
    pulse_clr(1);

    // buffer and command lockout
    wr_buf(8'h3C);
    chk("R7", "idle buffer write", int'(buf_q), 8'h3C);
    chk("R7", "no wcol when idle", int'(wcol_flag), 0);
    wr_reload(10);
    wr_cmd(5'b00001);
    wr_buf(8'hA5);
    chk("R7", "busy buffer unchanged", int'(buf_q), 8'h3C);
    chk("R7", "wcol set", int'(wcol_flag), 1);
    wr_cmd(5'b11110);
    chk("R8", "busy cmd write ignored", int'(cmd_bits), 5'b00001);
    begin
      int g;
      g = 0;
      while (!irq_flag && g < 100) begin @(negedge clk); g++; end
    end
    chk("R3", "locked START completes", int'(irq_flag), 1);
    wr_cmd(5'b10100);
    chk("R8", "cmd accepted after START", int'(cmd_bits), 5'b10100);
    pulse_clr(2);
    chk("R9", "wcol cleared", int'(wcol_flag), 0);
    pulse_clr(0);

    // release held SDA through a collision, then shortest period
    wr_cmd(5'b00001);
    @(negedge clk);
    pulse_clr(1);
    timed_start(0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule